// File: doc/BRIEF.md
# Serial Lane Word Aligner

This block sits behind a one-bit serial receive lane that is clocked at the bit rate. It turns the bit stream into parallel words of either 6 or 8 bits, with the width fixed by a parameter. The point where the stream is cut into words is arbitrary after power-up. The block finds the correct cut by itself. While the link sends its training word, every received word is compared with the expected value. On a mismatch the block delays the word boundary by one bit. It skips the words that follow the change and then compares again.

The search starts only once the upstream sampling-phase adjustment reports that it is done. After several matching words in a row the block reports lock and freezes its framing. If every possible framing has been tried without success, it reports failure and stops adjusting. A realign pulse restarts the search from the current framing.

Top module: `bitslip_aligner`

## Requirements
- R1: Serial bits enter most-significant first. Each captured word holds the last `WORD_W` bits received, with the oldest bit at the MSB of `word_o`. `word_o` changes only when a word is captured.
- R2: `word_valid_o` is high for exactly one cycle in the cycle after each capture, in every state. Strobes are `WORD_W` clocks apart. The one interval in which a slip is applied lasts `WORD_W`+1 clocks.
- R3: After reset or a realign, no comparison or slip takes place while `phase_ok_i` is low. `slip_count_o` stays 0 and neither flag is raised.
- R4: The expected training word is 6'b111000 when `WORD_W`=6 and 8'h38 when `WORD_W`=8. Each slip adds one to `slip_count_o` and delays the boundary by one bit, so the next framing shows the stream rotated left by one bit (for example 8'h1C becomes 8'h38).
- R5: After a slip, the next 2 valid words are not compared. The third valid word is compared.
- R6: `aligned_o` rises in the cycle after the 4th consecutive compared word equal to the training word. A mismatch before that clears the run and causes a slip.
- R7: If a compared word mismatches when `slip_count_o` already equals `WORD_W`, `align_fail_o` rises and no further slip happens. `slip_count_o` never exceeds `WORD_W`, and the two flags are never high together.
- R8: While `aligned_o` is high, the framing and `slip_count_o` stay fixed whatever data arrives.
- R9: A realign pulse clears `aligned_o`, `align_fail_o` and `slip_count_o` in the next cycle and restarts the search. The current framing is kept.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion must be synchronous to clk |
| sdata_i | input | 1 | Serial data bit, sampled on every rising edge |
| phase_ok_i | input | 1 | High once sampling-phase adjustment has finished |
| realign_i | input | 1 | One-cycle request to restart the boundary search |
| word_o | output | WORD_W | Last captured parallel word |
| word_valid_o | output | 1 | One-cycle strobe marking a newly captured word |
| aligned_o | output | 1 | Boundary found and frozen |
| align_fail_o | output | 1 | Every framing tried without lock |
| slip_count_o | output | $clog2(WORD_W+1) | Number of one-bit slips applied since reset or realign |

## Verification
The assertions assume that reset is released synchronously and that `realign_i` is a pulse sampled on a clock edge. They also assume the serial stream changes only between rising edges. The stimulus drives every input on the falling edge and holds `realign_i` high across a single rising edge. Under these assumptions the strobe spacing is always `WORD_W` or `WORD_W`+1 clocks. The stimulus also feeds a stream whose framing returns to lock only at the last permitted slip, which exercises the boundary between lock and failure.

// File: rtl/aln_pkg.sv
package aln_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_HUNT,
    ST_SETTLE,
    ST_LOCK,
    ST_FAIL
  } aln_state_e;

  // Training word for the supported widths: 111000 (6 bit) and 00111000 (8 bit)
  // share the same numeric value.
  function automatic logic [15:0] training_word(input int unsigned width);
    if (width <= 8) training_word = 16'h0038;
    else            training_word = 16'h0038;
  endfunction

endpackage

// File: rtl/aln_deser_front.sv
module aln_deser_front #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata_i,
  input  logic              hold_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap_en;

  always_comb begin
    shift_d = {shift_q[WORD_W-2:0], sdata_i};
    cap_en  = !hold_i && (cnt_q == LAST);
    if (hold_i)      cnt_d = cnt_q;
    else if (cap_en) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      valid_o <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_o <= '0;
    else if (cap_en) word_o <= shift_d;
  end

endmodule

// File: rtl/aln_word_match.sv
module aln_word_match #(
  parameter int                WORD_W  = 8,
  parameter logic [WORD_W-1:0] PATTERN = '0
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              match_o
);

  logic [WORD_W-1:0] bit_eq;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign bit_eq[i] = (word_i[i] == PATTERN[i]);
  end

  assign match_o = &bit_eq;

endmodule

// File: rtl/aln_align_ctrl.sv
module aln_align_ctrl
  import aln_pkg::*;
#(
  parameter int WORD_W       = 8,
  parameter int SETTLE_WORDS = 2,
  parameter int LOCK_WORDS   = 4,
  parameter int SLIP_W       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid_i,
  input  logic              match_i,
  input  logic              phase_ok_i,
  input  logic              realign_i,
  output logic              slip_o,
  output logic              aligned_o,
  output logic              fail_o,
  output logic [SLIP_W-1:0] slip_count_o
);

  localparam int SET_W  = $clog2(SETTLE_WORDS + 1);
  localparam int LOCK_W = $clog2(LOCK_WORDS + 1);
  localparam logic [SLIP_W-1:0] SLIP_MAX    = SLIP_W'(WORD_W);
  localparam logic [SET_W-1:0]  SETTLE_LAST = SET_W'(SETTLE_WORDS - 1);
  localparam logic [LOCK_W-1:0] LOCK_LAST   = LOCK_W'(LOCK_WORDS - 1);

  aln_state_e        state_q, state_d;
  logic [SET_W-1:0]  settle_q, settle_d;
  logic [LOCK_W-1:0] run_q, run_d;
  logic [SLIP_W-1:0] slips_q, slips_d;

  always_comb begin
    state_d  = state_q;
    settle_d = settle_q;
    run_d    = run_q;
    slips_d  = slips_q;
    slip_o   = 1'b0;
    if (realign_i) begin
      state_d  = ST_WAIT;
      settle_d = '0;
      run_d    = '0;
      slips_d  = '0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (phase_ok_i) begin
            state_d = ST_HUNT;
            run_d   = '0;
          end
        end
        ST_HUNT: begin
          if (word_valid_i) begin
            if (match_i) begin
              run_d = run_q + 1'b1;
              if (run_q == LOCK_LAST) state_d = ST_LOCK;
            end else if (slips_q == SLIP_MAX) begin
              state_d = ST_FAIL;
            end else begin
              slip_o   = 1'b1;
              slips_d  = slips_q + 1'b1;
              run_d    = '0;
              settle_d = '0;
              state_d  = ST_SETTLE;
            end
          end
        end
        ST_SETTLE: begin
          if (word_valid_i) begin
            if (settle_q == SETTLE_LAST) begin
              settle_d = '0;
              state_d  = ST_HUNT;
            end else begin
              settle_d = settle_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_WAIT;
      settle_q <= '0;
      run_q    <= '0;
      slips_q  <= '0;
    end else begin
      state_q  <= state_d;
      settle_q <= settle_d;
      run_q    <= run_d;
      slips_q  <= slips_d;
    end
  end

  assign aligned_o    = (state_q == ST_LOCK);
  assign fail_o       = (state_q == ST_FAIL);
  assign slip_count_o = slips_q;

endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int  WORD_W       = 8,
  parameter int  SETTLE_WORDS = 2,
  parameter int  LOCK_WORDS   = 4,
  localparam int SLIP_W       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata_i,
  input  logic              phase_ok_i,
  input  logic              realign_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              aligned_o,
  output logic              align_fail_o,
  output logic [SLIP_W-1:0] slip_count_o
);

  localparam logic [WORD_W-1:0] TRAIN = WORD_W'(aln_pkg::training_word(WORD_W));

  logic slip;
  logic match;

  aln_deser_front #(.WORD_W(WORD_W)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdata_i (sdata_i),
    .hold_i  (slip),
    .word_o  (word_o),
    .valid_o (word_valid_o)
  );

  aln_word_match #(.WORD_W(WORD_W), .PATTERN(TRAIN)) u_match (
    .word_i  (word_o),
    .match_o (match)
  );

  aln_align_ctrl #(
    .WORD_W       (WORD_W),
    .SETTLE_WORDS (SETTLE_WORDS),
    .LOCK_WORDS   (LOCK_WORDS),
    .SLIP_W       (SLIP_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid_i (word_valid_o),
    .match_i      (match),
    .phase_ok_i   (phase_ok_i),
    .realign_i    (realign_i),
    .slip_o       (slip),
    .aligned_o    (aligned_o),
    .fail_o       (align_fail_o),
    .slip_count_o (slip_count_o)
  );

endmodule

// File: rtl/aln_checker.sv
module aln_checker #(
  parameter int WORD_W = 8,
  parameter int SLIP_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              realign_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              aligned_o,
  input logic              align_fail_o,
  input logic [SLIP_W-1:0] slip_count_o
);

  localparam logic [WORD_W-1:0] TRAIN = WORD_W'(aln_pkg::training_word(WORD_W));

  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (word_valid_o) begin
      gap_q  <= 1;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1;
    end
  end

  // R2: strobe spacing is one word, or one word plus the slipped bit
  assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && seen_q) |-> (gap_q == WORD_W || gap_q == WORD_W + 1));

  // R4: the slip count only ever steps up by one (or returns to zero on realign)
  assert_slip_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_count_o != $past(slip_count_o)) |->
      (slip_count_o == $past(slip_count_o) + SLIP_W'(1) || slip_count_o == '0));

  // R6: lock follows a valid word equal to the training word
  assert_lock_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_o) |-> ($past(word_valid_o) && $past(word_o) == TRAIN));

  // R7: bounded slip count, exclusive flags
  assert_slip_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slip_count_o <= SLIP_W'(WORD_W));
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(aligned_o && align_fail_o));

  // R8: framing frozen while locked
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned_o && $past(aligned_o)) |-> $stable(slip_count_o));

  // R9: realign clears status in the next cycle
  assert_realign_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    realign_i |=> (slip_count_o == '0 && !aligned_o && !align_fail_o));

endmodule

bind bitslip_aligner aln_checker #(.WORD_W(WORD_W)) u_aln_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .realign_i    (realign_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .aligned_o    (aligned_o),
  .align_fail_o (align_fail_o),
  .slip_count_o (slip_count_o)
);

// File: tb/tb_bitslip_aligner.sv
module tb_bitslip_aligner;

  localparam int W  = 8;
  localparam int SW = $clog2(W + 1);
  localparam logic [7:0] PAT8 = 8'h38;
  localparam logic [5:0] PAT6 = 6'b111000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sdata, phase_ok, realign;
  logic [W-1:0] word;
  logic valid, aligned, fail;
  logic [SW-1:0] slips;

  logic sdata6;
  logic [5:0] word6;
  logic valid6, aligned6, fail6;
  logic [2:0] slips6;

  bitslip_aligner #(.WORD_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .phase_ok_i(phase_ok),
    .realign_i(realign), .word_o(word), .word_valid_o(valid),
    .aligned_o(aligned), .align_fail_o(fail), .slip_count_o(slips));

  bitslip_aligner #(.WORD_W(6)) dut6 (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata6), .phase_ok_i(1'b1),
    .realign_i(1'b0), .word_o(word6), .word_valid_o(valid6),
    .aligned_o(aligned6), .align_fail_o(fail6), .slip_count_o(slips6));

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference (bit-rate model) ----------------
  localparam int M_WAIT = 0, M_HUNT = 1, M_SETTLE = 2, M_LOCK = 3, M_FAIL = 4;
  logic [W-1:0] m_hist, m_word;
  bit  m_vld, m_slip;
  int  m_phase, m_mode, m_run, m_skip, m_slips;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = '0; m_word = '0; m_vld = 0; m_phase = 0;
      m_mode = M_WAIT; m_run = 0; m_skip = 0; m_slips = 0;
    end else begin
      m_slip = 0;
      if (realign) begin
        m_mode = M_WAIT; m_run = 0; m_skip = 0; m_slips = 0;
      end else if (m_mode == M_WAIT) begin
        if (phase_ok) begin m_mode = M_HUNT; m_run = 0; end
      end else if (m_mode == M_HUNT && m_vld) begin
        if (m_word == PAT8) begin
          m_run = m_run + 1;
          if (m_run == 4) m_mode = M_LOCK;          // R6
        end else if (m_slips == W) begin
          m_mode = M_FAIL;                          // R7
        end else begin
          m_slip = 1; m_slips = m_slips + 1; m_run = 0; m_skip = 0;
          m_mode = M_SETTLE;
        end
      end else if (m_mode == M_SETTLE && m_vld) begin
        m_skip = m_skip + 1;                        // R5: two words skipped
        if (m_skip == 2) begin m_skip = 0; m_mode = M_HUNT; end
      end
      m_vld = 0;
      if (!m_slip) begin
        if (m_phase == W - 1) begin
          m_word  = {m_hist[W-2:0], sdata};
          m_vld   = 1;
          m_phase = 0;
        end else begin
          m_phase = m_phase + 1;
        end
      end
      m_hist = {m_hist[W-2:0], sdata};
    end
  end

  // ---------------- stimulus ----------------
  int idx, idx6, stream, corrupt_left;   // stream: 0 training, 1 zeros, 2 ones

  task automatic drive_bits();
    bit b;
    b = PAT8[W-1 - (idx % W)];
    if (stream == 1) b = 1'b0;
    else if (stream == 2) b = 1'b1;
    if (corrupt_left > 0) begin
      b = ~b;
      corrupt_left--;
    end
    sdata  = b;
    idx++;
    sdata6 = PAT6[5 - (idx6 % 6)];
    idx6++;
  endtask

  task automatic compare_all();
    check(word == m_word, "R1 word_o", int'(word), int'(m_word));
    check(valid == m_vld, "R2 word_valid_o", int'(valid), int'(m_vld));
    check(aligned == (m_mode == M_LOCK), "R6 aligned_o", int'(aligned), int'(m_mode == M_LOCK));
    check(fail == (m_mode == M_FAIL), "R7 align_fail_o", int'(fail), int'(m_mode == M_FAIL));
    check(int'(slips) == m_slips, "R4 slip_count_o", int'(slips), m_slips);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    drive_bits();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int nvalid;
    rst_n = 1'b0; sdata = 1'b0; sdata6 = 1'b0; phase_ok = 1'b0; realign = 1'b0;
    idx = 0; idx6 = 0; stream = 0; corrupt_left = 0;
    repeat (3) tick();
    // R10: reset values
    check(word == '0 && !valid && !aligned && !fail && slips == '0, "R10 reset outputs",
          int'(word) + int'(valid) + int'(aligned) + int'(fail) + int'(slips), 0);
    rst_n = 1'b1;
    idx = W - 1;         // first word shows the training word rotated right by one bit
    idx6 = 5;
    drive_bits();

    // R3: no search while phase adjustment is pending
    repeat (5 * W) tick();
    check(slips == '0 && !aligned && !fail, "R3 idle without phase_ok", int'(slips), 0);
    check(word == 8'h1C, "R1 idle framing word", int'(word), 8'h1C);

    // R4/R5/R6: one slip fixes 8'h1C, then 2 skipped + 4 matching words
    phase_ok = 1'b1;
    nvalid = 0;
    for (int i = 0; i < 600 && !aligned; i++) begin
      tick();
      if (slips == SW'(1) && !aligned && valid) nvalid++;
    end
    check(aligned == 1'b1, "R6 lock reached", int'(aligned), 1);
    check(slips == SW'(1), "R4 one slip for rotated word", int'(slips), 1);
    check(word == PAT8, "R4 aligned word", int'(word), int'(PAT8));
    check(nvalid == 6, "R5 words between slip and lock", nvalid, 6);

    // R8: garbage after lock changes nothing about framing
    stream = 2;
    repeat (6 * W) tick();
    check(aligned && slips == SW'(1), "R8 lock held on bad data", int'(slips), 1);
    check(word == 8'hFF, "R8 data still flows", int'(word), 8'hFF);

    // R9: realign clears status; R7: no match ever leads to failure after W slips
    stream = 1;
    realign = 1'b1;
    tick();
    realign = 1'b0;
    check(!aligned && !fail && slips == '0, "R9 realign clears", int'(slips), 0);
    for (int i = 0; i < 3000 && !fail; i++) tick();
    check(fail == 1'b1, "R7 failure flagged", int'(fail), 1);
    check(slips == SW'(W), "R7 slip count at limit", int'(slips), W);
    repeat (5 * W) tick();
    check(fail && slips == SW'(W), "R7 no slip after failure", int'(slips), W);

    // R6: a broken run restarts with a slip; lock returns only at the last slip
    stream = 0;
    realign = 1'b1;
    tick();
    realign = 1'b0;
    for (int i = 0; i < 600 && !(m_mode == M_HUNT && m_run == 2); i++) tick();
    check(m_run == 2 && !aligned, "R6 partial run seen", m_run, 2);
    corrupt_left = W;
    for (int i = 0; i < 4000 && !aligned && !fail; i++) tick();
    check(aligned == 1'b1, "R6 relock after restart", int'(aligned), 1);
    check(slips == SW'(W), "R6 relock at final slip", int'(slips), W);
    check(word == PAT8, "R6 relocked word", int'(word), int'(PAT8));

    // R4: 6-bit instance aligns on 111000 after one slip
    check(aligned6 && word6 == PAT6, "R4 six-bit lock word", int'(word6), int'(PAT6));
    check(slips6 == 3'd1 && !fail6, "R4 six-bit slip count", int'(slips6), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule